// File: doc/BRIEF.md
# Four-Stage Floating-Point Adder/Subtractor

This block adds or subtracts two normalized floating-point operands in a four-stage pipeline. Each operand has a sign bit, an unsigned exponent and a mantissa read as a binary fraction. The fraction is normalized, so its most significant bit is one, and the operand's value is 0.m × 2^e. One operand pair and an add/subtract select can enter on every clock. The result comes out normalized, with the same format, after four register stages. There is no rounding. Bits shifted out during alignment are dropped.

The four stages run in a fixed order. Stage 1 compares the exponents and swaps the operands so the larger exponent leads. Stage 2 shifts the smaller operand's mantissa right to line up with the larger one. Stage 3 adds or subtracts the mantissas in signed magnitude. Stage 4 normalizes the result.

Both stream edges use valid/ready. A result is held on the output until `out_ready` is high. While a result is stalled the whole pipeline freezes and `in_ready` drops. An input is taken only on a clock where `in_valid` and `in_ready` are both high. Infinities, NaNs, denormals, exponent overflow or underflow, and exception flags are outside the block.

Top module: `fpadd_pipe`

## Requirements
- R1: An input accepted at clock edge k appears on the outputs with `out_valid` high after edge k+3, so it is visible after four edges counting edge k. With `out_ready` held high and an input offered on every clock, one result leaves per clock.
- R2: The result exponent before normalization is the larger of the two operand exponents. On a tie, operand A is taken as the larger.
- R3: The mantissa of the operand with the smaller exponent is shifted right by the exponent difference, and the bits shifted out are dropped. A difference of MW or more makes that mantissa zero, so the result equals the larger operand.
- R4: `in_sub` = 1 computes A − B by inverting B's sign before the magnitudes are combined. `in_sub` = 0 computes A + B.
- R5: When the effective signs differ, the smaller aligned magnitude is subtracted from the larger one. The result takes the sign of the larger magnitude.
- R6: When the magnitude sum overflows past bit MW−1, the mantissa is shifted right by one place and the exponent is incremented by one.
- R7: A nonzero result with leading zero fraction bits is shifted left until bit MW−1 is one, and the exponent is decremented once per shift. Every valid nonzero result has `z_man[MW-1]` = 1.
- R8: An exact zero result is output as mantissa 0, exponent 0 and sign 0.
- R9: While `out_valid` is high and `out_ready` is low, the outputs hold their values and `in_ready` is low.
- R10: A synchronous active-high `rst` clears every stage's valid bit. After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Pipeline can take an operand pair |
| in_sub | input | 1 | 1 = subtract B from A, 0 = add |
| a_sign | input | 1 | Sign of A (1 = negative) |
| a_exp | input | EW | Exponent of A |
| a_man | input | MW | Normalized fraction mantissa of A |
| b_sign | input | 1 | Sign of B |
| b_exp | input | EW | Exponent of B |
| b_man | input | MW | Normalized fraction mantissa of B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| z_sign | output | 1 | Result sign |
| z_exp | output | EW | Result exponent |
| z_man | output | MW | Result mantissa |

## Verification
A fault in the swap or shift logic of the first two stages shows up as a wrong exponent or a wrong mantissa. It appears four edges after the affected operand pair is accepted, and it affects only that pair. A fault in a stage valid bit or in the stall enable shows up at the ports in a different way: a result is lost, duplicated or moved in time. A scoreboard that matches results in order catches this at the first output that goes missing or arrives out of place. If the normalizer loses a leading-zero count, the result shows a cleared top mantissa bit on the same cycle it becomes valid. If the normalizer gets zero detection wrong, the result shows a non-canonical zero on the same cycle it becomes valid.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int unsigned DEF_EW = 8;
  localparam int unsigned DEF_MW = 16;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fp_op_e;
endpackage

// File: rtl/fpadd_cmp.sv
module fpadd_cmp #(
  parameter int unsigned EW = fpadd_pkg::DEF_EW,
  parameter int unsigned MW = fpadd_pkg::DEF_MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          i_vld,
  input  logic          i_sub,
  input  logic          i_as,
  input  logic [EW-1:0] i_ae,
  input  logic [MW-1:0] i_am,
  input  logic          i_bs,
  input  logic [EW-1:0] i_be,
  input  logic [MW-1:0] i_bm,
  output logic          o_vld,
  output logic [EW-1:0] o_exp,
  output logic [EW-1:0] o_dif,
  output logic          o_lsgn,
  output logic [MW-1:0] o_lman,
  output logic          o_ssgn,
  output logic [MW-1:0] o_sman
);
  logic b_eff;
  logic a_lead;

  always_comb begin
    b_eff  = i_bs ^ (fpadd_pkg::fp_op_e'(i_sub) == fpadd_pkg::OP_SUB);
    a_lead = (i_ae >= i_be);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
    end else if (adv) begin
      o_vld <= i_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      if (a_lead) begin
        o_exp  <= i_ae;
        o_dif  <= i_ae - i_be;
        o_lsgn <= i_as;
        o_lman <= i_am;
        o_ssgn <= b_eff;
        o_sman <= i_bm;
      end else begin
        o_exp  <= i_be;
        o_dif  <= i_be - i_ae;
        o_lsgn <= b_eff;
        o_lman <= i_bm;
        o_ssgn <= i_as;
        o_sman <= i_am;
      end
    end
  end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int unsigned EW = fpadd_pkg::DEF_EW,
  parameter int unsigned MW = fpadd_pkg::DEF_MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          i_vld,
  input  logic [EW-1:0] i_exp,
  input  logic [EW-1:0] i_dif,
  input  logic          i_lsgn,
  input  logic [MW-1:0] i_lman,
  input  logic          i_ssgn,
  input  logic [MW-1:0] i_sman,
  output logic          o_vld,
  output logic [EW-1:0] o_exp,
  output logic          o_lsgn,
  output logic [MW-1:0] o_lman,
  output logic          o_ssgn,
  output logic [MW-1:0] o_sman
);
  logic [MW-1:0] shifted;

  always_comb begin
    if (32'(i_dif) >= MW) shifted = '0;
    else                  shifted = i_sman >> i_dif;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
    end else if (adv) begin
      o_vld <= i_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      o_exp  <= i_exp;
      o_lsgn <= i_lsgn;
      o_lman <= i_lman;
      o_ssgn <= i_ssgn;
      o_sman <= shifted;
    end
  end
endmodule

// File: rtl/fpadd_addsub.sv
module fpadd_addsub #(
  parameter int unsigned EW = fpadd_pkg::DEF_EW,
  parameter int unsigned MW = fpadd_pkg::DEF_MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          i_vld,
  input  logic [EW-1:0] i_exp,
  input  logic          i_lsgn,
  input  logic [MW-1:0] i_lman,
  input  logic          i_ssgn,
  input  logic [MW-1:0] i_sman,
  output logic          o_vld,
  output logic [EW-1:0] o_exp,
  output logic          o_sgn,
  output logic [MW:0]   o_mag
);
  logic [MW:0] mag;
  logic        sgn;

  always_comb begin
    if (i_lsgn == i_ssgn) begin
      mag = {1'b0, i_lman} + {1'b0, i_sman};
      sgn = i_lsgn;
    end else if (i_lman >= i_sman) begin
      mag = {1'b0, i_lman} - {1'b0, i_sman};
      sgn = i_lsgn;
    end else begin
      mag = {1'b0, i_sman} - {1'b0, i_lman};
      sgn = i_ssgn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
    end else if (adv) begin
      o_vld <= i_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      o_exp <= i_exp;
      o_sgn <= sgn;
      o_mag <= mag;
    end
  end
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm #(
  parameter int unsigned EW = fpadd_pkg::DEF_EW,
  parameter int unsigned MW = fpadd_pkg::DEF_MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          i_vld,
  input  logic [EW-1:0] i_exp,
  input  logic          i_sgn,
  input  logic [MW:0]   i_mag,
  output logic          o_vld,
  output logic          o_sgn,
  output logic [EW-1:0] o_exp,
  output logic [MW-1:0] o_man
);
  localparam int unsigned LZW = $clog2(MW + 1);

  logic [LZW-1:0] lz;
  logic           found;
  logic           n_sgn;
  logic [EW-1:0]  n_exp;
  logic [MW-1:0]  n_man;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = int'(MW) - 1; i >= 0; i--) begin
      if (!found) begin
        if (i_mag[i]) found = 1'b1;
        else          lz    = lz + 1'b1;
      end
    end
  end

  always_comb begin
    if (i_mag[MW]) begin
      n_man = i_mag[MW:1];
      n_exp = i_exp + 1'b1;
      n_sgn = i_sgn;
    end else if (!found) begin
      n_man = '0;
      n_exp = '0;
      n_sgn = 1'b0;
    end else begin
      n_man = i_mag[MW-1:0] << lz;
      n_exp = i_exp - EW'(lz);
      n_sgn = i_sgn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
      o_sgn <= 1'b0;
      o_exp <= '0;
      o_man <= '0;
    end else if (adv) begin
      o_vld <= i_vld;
      o_sgn <= n_sgn;
      o_exp <= n_exp;
      o_man <= n_man;
    end
  end
endmodule

// File: rtl/fpadd_pipe.sv
module fpadd_pipe #(
  parameter int unsigned EW = fpadd_pkg::DEF_EW,
  parameter int unsigned MW = fpadd_pkg::DEF_MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sub,
  input  logic          a_sign,
  input  logic [EW-1:0] a_exp,
  input  logic [MW-1:0] a_man,
  input  logic          b_sign,
  input  logic [EW-1:0] b_exp,
  input  logic [MW-1:0] b_man,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          z_sign,
  output logic [EW-1:0] z_exp,
  output logic [MW-1:0] z_man
);
  logic          adv;
  logic          s1_vld, s1_ls, s1_ss;
  logic [EW-1:0] s1_exp, s1_dif;
  logic [MW-1:0] s1_lm, s1_sm;
  logic          s2_vld, s2_ls, s2_ss;
  logic [EW-1:0] s2_exp;
  logic [MW-1:0] s2_lm, s2_sm;
  logic          s3_vld, s3_sgn;
  logic [EW-1:0] s3_exp;
  logic [MW:0]   s3_mag;

  always_comb begin
    adv      = !out_valid || out_ready;
    in_ready = adv;
  end

  fpadd_cmp #(.EW(EW), .MW(MW)) u_cmp (
    .clk(clk), .rst(rst), .adv(adv), .i_vld(in_valid && adv), .i_sub(in_sub),
    .i_as(a_sign), .i_ae(a_exp), .i_am(a_man),
    .i_bs(b_sign), .i_be(b_exp), .i_bm(b_man),
    .o_vld(s1_vld), .o_exp(s1_exp), .o_dif(s1_dif),
    .o_lsgn(s1_ls), .o_lman(s1_lm), .o_ssgn(s1_ss), .o_sman(s1_sm)
  );

  fpadd_align #(.EW(EW), .MW(MW)) u_align (
    .clk(clk), .rst(rst), .adv(adv), .i_vld(s1_vld), .i_exp(s1_exp),
    .i_dif(s1_dif), .i_lsgn(s1_ls), .i_lman(s1_lm), .i_ssgn(s1_ss), .i_sman(s1_sm),
    .o_vld(s2_vld), .o_exp(s2_exp), .o_lsgn(s2_ls), .o_lman(s2_lm),
    .o_ssgn(s2_ss), .o_sman(s2_sm)
  );

  fpadd_addsub #(.EW(EW), .MW(MW)) u_addsub (
    .clk(clk), .rst(rst), .adv(adv), .i_vld(s2_vld), .i_exp(s2_exp),
    .i_lsgn(s2_ls), .i_lman(s2_lm), .i_ssgn(s2_ss), .i_sman(s2_sm),
    .o_vld(s3_vld), .o_exp(s3_exp), .o_sgn(s3_sgn), .o_mag(s3_mag)
  );

  fpadd_norm #(.EW(EW), .MW(MW)) u_norm (
    .clk(clk), .rst(rst), .adv(adv), .i_vld(s3_vld), .i_exp(s3_exp),
    .i_sgn(s3_sgn), .i_mag(s3_mag),
    .o_vld(out_valid), .o_sgn(z_sign), .o_exp(z_exp), .o_man(z_man)
  );
endmodule

// File: rtl/fpadd_pipe_chk.sv
module fpadd_pipe_chk #(
  parameter int unsigned EW = fpadd_pkg::DEF_EW,
  parameter int unsigned MW = fpadd_pkg::DEF_MW
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_sub,
  input logic          a_sign,
  input logic [EW-1:0] a_exp,
  input logic [MW-1:0] a_man,
  input logic          b_sign,
  input logic [EW-1:0] b_exp,
  input logic [MW-1:0] b_man,
  input logic          out_valid,
  input logic          out_ready,
  input logic          z_sign,
  input logic [EW-1:0] z_exp,
  input logic [MW-1:0] z_man
);
  // R8: a zero mantissa is always the canonical positive zero
  p_zero_canon_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && z_man == '0) |-> (z_exp == '0 && !z_sign));

  // R7: every valid nonzero result is normalized
  p_norm_msb_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && z_man != '0) |-> z_man[MW-1]);

  // R9: a stalled result stays put
  p_hold_out_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(z_man) && $stable(z_exp) && $stable(z_sign)));

  // R9: no input is taken while the output is stalled
  p_block_in_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R10: reset empties the pipeline
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind fpadd_pipe fpadd_pipe_chk #(.EW(EW), .MW(MW)) u_chk (.*);

// File: tb/fpadd_pipe_test.sv
module fpadd_pipe_test;
  localparam int EW = 8;
  localparam int MW = 16;
  localparam int RW = 1 + EW + MW;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, in_sub;
  logic a_sign, b_sign, z_sign;
  logic [EW-1:0] a_exp, b_exp, z_exp;
  logic [MW-1:0] a_man, b_man, z_man;
  logic out_valid, out_ready;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [RW-1:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  fpadd_pipe #(.EW(EW), .MW(MW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_sub(in_sub),
    .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
    .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
    .out_valid(out_valid), .out_ready(out_ready),
    .z_sign(z_sign), .z_exp(z_exp), .z_man(z_man)
  );

  // Expected result from the requirements: swap, truncating shift, signed magnitude, normalize
  function automatic logic [RW-1:0] model(input logic as, input int ae, input int am,
                                          input logic bs, input int be, input int bm,
                                          input logic sub);
    logic bse, ls, ss, s;
    int le, d, lm, sm, r, e;
    bse = bs ^ sub;
    if (ae >= be) begin le = ae; d = ae - be; ls = as;  lm = am; ss = bse; sm = bm; end
    else          begin le = be; d = be - ae; ls = bse; lm = bm; ss = as;  sm = am; end
    sm = (d >= MW) ? 0 : (sm >> d);
    if (ls == ss)     begin r = lm + sm; s = ls; end
    else if (lm >= sm) begin r = lm - sm; s = ls; end
    else               begin r = sm - lm; s = ss; end
    e = le;
    if (r == 0) return '0;
    if (r >= (1 << MW)) begin r = r >> 1; e = e + 1; end
    else while (r < (1 << (MW - 1))) begin r = r << 1; e = e - 1; end
    return {s, EW'(e), MW'(r)};
  endfunction

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic drive(input logic as, input int ae, input int am,
                       input logic bs, input int be, input int bm, input logic sub);
    a_sign = as; a_exp = EW'(ae); a_man = MW'(am);
    b_sign = bs; b_exp = EW'(be); b_man = MW'(bm);
    in_sub = sub;
  endtask

  // Directed corner cases first, random afterwards
  task automatic pick(input int idx, output string tag);
    int ea, eb;
    case (idx)
      0: begin drive(0, 20, 'h8000, 0, 20, 'h8000, 0); tag = "R6"; end
      1: begin drive(0, 20, 'h8000, 0, 20, 'h8000, 1); tag = "R8"; end
      2: begin drive(0, 50, 'hC000, 0, 30, 'hFFFF, 0); tag = "R3"; end
      3: begin drive(0, 40, 'h8001, 0, 40, 'h8000, 1); tag = "R7"; end
      4: begin drive(0, 30, 'h9000, 1, 33, 'hA000, 0); tag = "R2"; end
      5: begin drive(0, 40, 'h8000, 0, 40, 'hC000, 1); tag = "R5"; end
      6: begin drive(1, 40, 'h8000, 0, 42, 'h8000, 1); tag = "R4"; end
      7: begin drive(0, 60, 'hFFFF, 0, 60, 'hFFFF, 0); tag = "R6"; end
      default: begin
        ea = 30 + int'($urandom % 160);
        eb = ea + int'($urandom % 41) - 20;
        drive(1'($urandom), ea, 'h8000 | int'($urandom % 'h8000),
              1'($urandom), eb, 'h8000 | int'($urandom % 'h8000), 1'($urandom));
        tag = "R1";
      end
    endcase
  endtask

  task automatic push_expected(input string tag);
    exp_q.push_back(model(a_sign, int'(a_exp), int'(a_man), b_sign, int'(b_exp), int'(b_man), in_sub));
    tag_q.push_back(tag);
  endtask

  task automatic pop_compare();
    if (exp_q.size() == 0) begin
      check("R1 unexpected output", {z_sign, z_exp, z_man}, '0);
      total--; bad += 0;
    end else begin
      check(tag_q.pop_front(), {z_sign, z_exp, z_man}, exp_q.pop_front());
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string tag;
    int idx, gaps;
    logic stalled;
    logic [RW-1:0] held;
    logic pend;
    void'($urandom(32'd2024));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 out_valid after reset", {24'd0, out_valid}, '0);
    check("R10 in_ready after reset", {24'd0, in_ready}, 25'd1);
    rst = 1'b0;

    // R1 latency: one operand pair, watch when it emerges
    @(negedge clk);
    drive(0, 70, 'hA000, 0, 68, 'hC000, 0);
    in_valid = 1'b1;
    push_expected("R1 latency data");
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 not valid after three edges", {24'd0, out_valid}, '0);
    @(negedge clk);
    check("R1 valid after four edges", {24'd0, out_valid}, 25'd1);
    if (out_valid) pop_compare();

    // R1 streaming: an input every clock, output every clock once full
    idx = 0; gaps = 0;
    for (int j = 0; j < 300; j++) begin
      @(negedge clk);
      if (j >= 4 && !out_valid) gaps++;
      if (out_valid) pop_compare();
      pick(idx, tag); idx++;
      in_valid = 1'b1; out_ready = 1'b1;
      #1;
      push_expected(tag);
    end
    check("R1 throughput gaps", 25'(gaps), '0);

    // R9 back-pressure with random ready and valid
    stalled = 1'b0; held = '0; pend = 1'b0;
    for (int j = 0; j < 3000; j++) begin
      @(negedge clk);
      if (stalled) begin
        check("R9 held output", {z_sign, z_exp, z_man}, held);
        check("R9 valid kept", {24'd0, out_valid}, 25'd1);
      end
      out_ready = ($urandom % 3) != 0;
      if (!pend) begin
        in_valid = ($urandom % 4) != 0;
        pick(idx, tag); idx++;
      end
      #1;
      if (out_valid && !out_ready)
        check("R9 in_ready low while stalled", {24'd0, in_ready}, '0);
      if (out_valid && out_ready) pop_compare();
      if (in_valid && in_ready) push_expected(tag);
      pend    = in_valid && !in_ready;
      stalled = out_valid && !out_ready;
      held    = {z_sign, z_exp, z_man};
    end

    // drain
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    for (int j = 0; j < 12; j++) begin
      #1;
      if (out_valid) pop_compare();
      @(negedge clk);
    end
    check("R1 all results delivered", 25'(exp_q.size()), '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule